// File: doc/BRIEF.md
# Voice Recorder Serial Control Port

This block is the digital control side of a single-chip voice record/playback device. A host microcontroller drives it as an SPI slave. Each command frame carries an optional row address and five control bits: cueing, continue-from-counter, power, play/record select and run. While the command bits shift in, the block shifts out its status flags and its current row pointer. The frame takes effect when the select line rises.

A row engine stands in for the storage array. Its row counter steps through the rows at a fixed row period, with a one-cycle row-clock pulse at each row boundary. Recording is modelled as marking rows. When a recording stops, the block sets an end-of-message mark on the current row. A later playback stops with an end-of-message flag when it finishes a marked row. If the counter runs past the last row, the block sets an overflow flag. Either flag pulls the active-low interrupt line low until the host reads the status out over MISO.

All serial inputs are synchronised into the system clock domain. A free-running divide-by-two of that clock provides the time base for the row timer and for the power-up settling delay.

Top module: `voice_ctl_port`

## Requirements
- R1: A frame is shifted while `ss_ni` is low. MOSI is sampled on each rising SCLK edge, least significant bit first, and the frame is applied when `ss_ni` rises. In a 16-bit frame, bits 0..10 are the row address and bits 11..15 are, in order, cue, continue, power, play (1 = play, 0 = record) and run.
- R2: An 8-bit frame carries the five control bits in its bits 3..7. Bits 0..2 are ignored, and the frame leaves the row counter unchanged, as if continue were set. A frame of any other length leaves the block's state unchanged.
- R3: MISO presents, in this order: overflow, end of message, then the row pointer LSB first. It presents zero after that. The first bit is valid once `ss_ni` has fallen, and each later bit follows a falling SCLK edge. While the block is deselected, `miso_o` is 1 (released).
- R4: A command with power set, sent while the block is powered down, starts a settling delay of SETTLE_TICKS time-base ticks (two clock cycles each). `ready_o` stays low until the delay has passed. A run request made while not ready is ignored.
- R5: While running, `row_clk_o` pulses for one cycle at each row end. In normal mode the row period is 2*ROW_TICKS clock cycles. Every accepted run command restarts the row timer.
- R6: A run command with continue clear loads its address into the row counter. The counter then stays on that row at each row end, so the operation repeats the same row.
- R7: A run command with continue set discards its address. The counter advances by one row at each row end.
- R8: When the counter advances past the last row (NUM_ROWS-1), the overflow flag is set, the run stops, the pointer stays on the last row and `int_no` goes low.
- R9: Stopping a recording (run clear or power down) marks the current row as end of message. A recording that passes a row clears that row's mark. A playback that finishes a marked row sets the end-of-message flag, stops, keeps the pointer on that row and pulls `int_no` low.
- R10: A frame that shifts at least two bits clears whichever flags it shifted out as set, and `int_no` returns high.
- R11: Cueing is taken only at the start of a playback. It shortens the row period by CUE_DIV, to 2*(ROW_TICKS/CUE_DIV) cycles. Cueing requested with record is ignored.
- R12: A command with power clear stops any run and drops `pwr_o` and `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Open-drain serial data to the host; 0 pulls the line low, 1 releases it |
| run_o | output | 1 | Operation in progress |
| play_o | output | 1 | 1 = playback, 0 = record |
| pwr_o | output | 1 | Powered up |
| ready_o | output | 1 | Settling delay over, operations accepted |
| row_clk_o | output | 1 | One-cycle pulse at each row end |
| int_no | output | 1 | Interrupt, active low, on overflow or end of message |

## Verification
The bench builds the block with 12 rows, a 160-tick row period, a cue divider of 4 and a 30-tick settling delay. A row then lasts 320 cycles, which is longer than a full 16-bit frame. A command can therefore be applied and the row pointer read back inside a single row. Overflow is reached by starting two rows short of the end, and the cue period of 80 cycles can be measured exactly between two row pulses.

// File: rtl/voice_ctl_pkg.sv
package voice_ctl_pkg;

  localparam int FRAME_W = 16;
  localparam int SHORT_W = 8;
  localparam int ADDR_W  = 11;
  localparam int CTL_W   = 5;
  localparam int CNT_W   = 5;

  // LSB first on the wire: cue is frame bit 11, run is frame bit 15
  typedef struct packed {
    logic run;
    logic play;
    logic pwr_up;
    logic cont;
    logic cue;
  } ctl_t;

  typedef struct packed {
    logic              valid;
    logic              has_addr;
    ctl_t              ctl;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

endpackage

// File: rtl/voice_spi_rx.sv
module voice_spi_rx
  import voice_ctl_pkg::*;
#(
  parameter int STAT_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               ss_ni,
  input  logic               mosi_i,
  input  logic [STAT_W-1:0]  stat_i,
  output logic               miso_o,
  output logic               frame_o,
  output logic [CNT_W-1:0]   frame_bits_o,
  output logic [FRAME_W-1:0] frame_data_o,
  output logic               rd_o,
  output logic [1:0]         rd_flags_o
);

  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0]  sclk_q, ss_q;
  logic [1:0]         mosi_q;
  logic [FRAME_W-1:0] in_sr;
  logic [STAT_W-1:0]  out_sr;
  logic [CNT_W-1:0]   cnt_q;
  logic [1:0]         snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC_N-2:0], sclk_i};
      ss_q   <= {ss_q[SYNC_N-2:0], ss_ni};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  logic sel, ss_fall, ss_rise, sck_rise, sck_fall;
  assign sel      = ~ss_q[1];
  assign ss_fall  = ~ss_q[1] & ss_q[2];
  assign ss_rise  = ss_q[1] & ~ss_q[2];
  assign sck_rise = sel & sclk_q[1] & ~sclk_q[2];
  assign sck_fall = sel & ~sclk_q[1] & sclk_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sr   <= '0;
      out_sr  <= '0;
      cnt_q   <= '0;
      snap_q  <= '0;
      frame_o <= 1'b0;
      rd_o    <= 1'b0;
    end else begin
      frame_o <= 1'b0;
      rd_o    <= 1'b0;
      if (ss_fall) begin
        out_sr <= stat_i;
        snap_q <= stat_i[1:0];
        cnt_q  <= '0;
      end else if (sel) begin
        if (sck_rise) begin
          in_sr <= {mosi_q[1], in_sr[FRAME_W-1:1]};
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
        if (sck_fall) out_sr <= {1'b0, out_sr[STAT_W-1:1]};
      end
      if (ss_rise) begin
        frame_o <= 1'b1;
        rd_o    <= (cnt_q >= CNT_W'(2));
      end
    end
  end

  assign miso_o       = sel ? out_sr[0] : 1'b1;
  assign frame_bits_o = cnt_q;
  assign frame_data_o = in_sr;
  assign rd_flags_o   = snap_q;

endmodule

// File: rtl/voice_cmd_dec.sv
module voice_cmd_dec
  import voice_ctl_pkg::*;
#(
  parameter int NUM_ROWS = 600,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic               frame_i,
  input  logic [CNT_W-1:0]   bits_i,
  input  logic [FRAME_W-1:0] data_i,
  output cmd_t               cmd_o,
  output logic [ROW_W-1:0]   row_o
);

  logic is_long, is_short;
  assign is_long  = (bits_i == CNT_W'(FRAME_W));
  assign is_short = (bits_i == CNT_W'(SHORT_W));

  always_comb begin
    cmd_o.valid    = frame_i & (is_long | is_short);
    cmd_o.has_addr = is_long;
    cmd_o.ctl      = ctl_t'(data_i[FRAME_W-1 -: CTL_W]);
    cmd_o.addr     = data_i[ADDR_W-1:0];
  end

  // out-of-range addresses land on the last row
  always_comb begin
    if (32'(cmd_o.addr) >= 32'(NUM_ROWS)) row_o = ROW_W'(NUM_ROWS - 1);
    else                                   row_o = cmd_o.addr[ROW_W-1:0];
  end

endmodule

// File: rtl/voice_row_engine.sv
module voice_row_engine
  import voice_ctl_pkg::*;
#(
  parameter int NUM_ROWS     = 600,
  parameter int ROW_TICKS    = 3200,
  parameter int CUE_DIV      = 1600,
  parameter int SETTLE_TICKS = 100000,
  parameter int ROW_W        = $clog2(NUM_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_t             cmd_i,
  input  logic [ROW_W-1:0] cmd_row_i,
  input  logic             rd_i,
  input  logic [1:0]       rd_flags_i,
  output logic             run_o,
  output logic             play_o,
  output logic             pwr_o,
  output logic             ready_o,
  output logic             row_clk_o,
  output logic             int_no,
  output logic [ROW_W+1:0] stat_o
);

  localparam int CUE_TICKS = (ROW_TICKS / CUE_DIV > 0) ? ROW_TICKS / CUE_DIV : 1;
  localparam int TW        = $clog2(ROW_TICKS + 1);
  localparam int SW        = $clog2(SETTLE_TICKS + 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  logic                tick_q;
  logic                pwr_q, ready_q, run_q, play_q, cue_q, cont_q;
  logic                ovf_q, eom_q;
  logic [SW-1:0]       settle_q;
  logic [TW-1:0]       timer_q;
  logic [ROW_W-1:0]    row_q;
  logic [NUM_ROWS-1:0] mark_q;
  logic                row_clk_q;
  logic [TW-1:0]       row_last;

  assign row_last = cue_q ? TW'(CUE_TICKS - 1) : TW'(ROW_TICKS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q    <= 1'b0;
      pwr_q     <= 1'b0;
      ready_q   <= 1'b0;
      run_q     <= 1'b0;
      play_q    <= 1'b0;
      cue_q     <= 1'b0;
      cont_q    <= 1'b0;
      ovf_q     <= 1'b0;
      eom_q     <= 1'b0;
      settle_q  <= '0;
      timer_q   <= '0;
      row_q     <= '0;
      mark_q    <= '0;
      row_clk_q <= 1'b0;
    end else begin
      tick_q    <= ~tick_q;
      row_clk_q <= 1'b0;

      if (rd_i) begin
        if (rd_flags_i[0]) ovf_q <= 1'b0;
        if (rd_flags_i[1]) eom_q <= 1'b0;
      end

      if (tick_q && pwr_q && !ready_q) begin
        if (settle_q == SW'(SETTLE_TICKS - 1)) ready_q <= 1'b1;
        else                                   settle_q <= settle_q + 1'b1;
      end

      if (tick_q && run_q) begin
        if (timer_q == row_last) begin
          timer_q   <= '0;
          row_clk_q <= 1'b1;
          if (play_q && mark_q[row_q]) begin
            eom_q <= 1'b1;
            run_q <= 1'b0;
          end else begin
            if (!play_q) mark_q[row_q] <= 1'b0;
            if (cont_q) begin
              if (row_q == LAST_ROW) begin
                ovf_q <= 1'b1;
                run_q <= 1'b0;
              end else begin
                row_q <= row_q + 1'b1;
              end
            end
          end
        end else begin
          timer_q <= timer_q + 1'b1;
        end
      end

      if (cmd_i.valid) begin
        if (!cmd_i.ctl.pwr_up) begin
          pwr_q   <= 1'b0;
          ready_q <= 1'b0;
          if (run_q && !play_q) mark_q[row_q] <= 1'b1;
          run_q   <= 1'b0;
        end else begin
          if (!pwr_q) begin
            pwr_q    <= 1'b1;
            settle_q <= '0;
          end
          if (cmd_i.ctl.run) begin
            if (ready_q) begin
              timer_q <= '0;
              cont_q  <= cmd_i.ctl.cont | ~cmd_i.has_addr;
              if (cmd_i.has_addr && !cmd_i.ctl.cont) row_q <= cmd_row_i;
              play_q  <= cmd_i.ctl.play;
              if (!run_q) cue_q <= cmd_i.ctl.cue & cmd_i.ctl.play;
              run_q   <= 1'b1;
            end
          end else begin
            if (run_q && !play_q) mark_q[row_q] <= 1'b1;
            run_q <= 1'b0;
          end
        end
      end
    end
  end

  assign run_o     = run_q;
  assign play_o    = play_q;
  assign pwr_o     = pwr_q;
  assign ready_o   = ready_q;
  assign row_clk_o = row_clk_q;
  assign int_no    = ~(ovf_q | eom_q);
  assign stat_o    = {row_q, eom_q, ovf_q};

endmodule

// File: rtl/voice_ctl_port.sv
module voice_ctl_port
  import voice_ctl_pkg::*;
#(
  parameter int NUM_ROWS     = 600,
  parameter int ROW_TICKS    = 3200,
  parameter int CUE_DIV      = 1600,
  parameter int SETTLE_TICKS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic ss_ni,
  input  logic mosi_i,
  output logic miso_o,
  output logic run_o,
  output logic play_o,
  output logic pwr_o,
  output logic ready_o,
  output logic row_clk_o,
  output logic int_no
);

  localparam int ROW_W  = $clog2(NUM_ROWS);
  localparam int STAT_W = ROW_W + 2;

  logic               frame;
  logic [CNT_W-1:0]   frame_bits;
  logic [FRAME_W-1:0] frame_data;
  logic               rd;
  logic [1:0]         rd_flags;
  logic [STAT_W-1:0]  stat;
  cmd_t               cmd;
  logic [ROW_W-1:0]   cmd_row;

  voice_spi_rx #(.STAT_W(STAT_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_i),
    .ss_ni        (ss_ni),
    .mosi_i       (mosi_i),
    .stat_i       (stat),
    .miso_o       (miso_o),
    .frame_o      (frame),
    .frame_bits_o (frame_bits),
    .frame_data_o (frame_data),
    .rd_o         (rd),
    .rd_flags_o   (rd_flags)
  );

  voice_cmd_dec #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_dec (
    .frame_i (frame),
    .bits_i  (frame_bits),
    .data_i  (frame_data),
    .cmd_o   (cmd),
    .row_o   (cmd_row)
  );

  voice_row_engine #(
    .NUM_ROWS     (NUM_ROWS),
    .ROW_TICKS    (ROW_TICKS),
    .CUE_DIV      (CUE_DIV),
    .SETTLE_TICKS (SETTLE_TICKS),
    .ROW_W        (ROW_W)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .cmd_row_i  (cmd_row),
    .rd_i       (rd),
    .rd_flags_i (rd_flags),
    .run_o      (run_o),
    .play_o     (play_o),
    .pwr_o      (pwr_o),
    .ready_o    (ready_o),
    .row_clk_o  (row_clk_o),
    .int_no     (int_no),
    .stat_o     (stat)
  );

endmodule

// File: rtl/voice_ctl_port_chk.sv
module voice_ctl_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ss_ni,
  input logic miso_o,
  input logic run_o,
  input logic pwr_o,
  input logic ready_o,
  input logic row_clk_o
);

  assert_miso_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_ni && $past(ss_ni) && $past(ss_ni, 2) && $past(ss_ni, 3)) |-> miso_o);

  assert_run_needs_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> ready_o);

  assert_settle_after_power_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(pwr_o));

  assert_row_pulse_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_clk_o |-> $past(run_o));

  assert_row_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_clk_o |=> !row_clk_o);

  assert_ready_needs_power_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> pwr_o);

endmodule

bind voice_ctl_port voice_ctl_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ss_ni     (ss_ni),
  .miso_o    (miso_o),
  .run_o     (run_o),
  .pwr_o     (pwr_o),
  .ready_o   (ready_o),
  .row_clk_o (row_clk_o)
);

// File: tb/voice_ctl_port_bench.sv
`timescale 1ns/1ps
module voice_ctl_port_bench;

  localparam int NR   = 12;
  localparam int RT   = 160;
  localparam int CD   = 4;
  localparam int ST   = 30;
  localparam int ROWC = 2 * RT;
  localparam int CUEC = 2 * (RT / CD);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, run, play, pwr, ready, row_clk, int_n;
  int   nvec = 0, nfail = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  voice_ctl_port #(.NUM_ROWS(NR), .ROW_TICKS(RT), .CUE_DIV(CD), .SETTLE_TICKS(ST)) u_voice_ctl_port (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso), .run_o(run), .play_o(play), .pwr_o(pwr), .ready_o(ready),
    .row_clk_o(row_clk), .int_no(int_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd16(input int addr, input bit cue, cont, pu, pl, rn);
    return {rn, pl, pu, cont, cue, 11'(addr)};
  endfunction

  function automatic logic [15:0] cmd8(input bit cue, cont, pu, pl, rn);
    return {8'h00, rn, pl, pu, cont, cue, 3'b000};
  endfunction

  task automatic xfer(input logic [15:0] d, input int n, output logic [15:0] so);
    so = '0;
    ss_n = 1'b0;
    step(6);
    for (int i = 0; i < n; i++) begin
      mosi = d[i];
      step(3);
      so[i] = miso;
      sclk = 1'b1;
      step(4);
      sclk = 1'b0;
      step(1);
    end
    step(4);
    ss_n = 1'b1;
    step(6);
  endtask

  task automatic send(input logic [15:0] d, input int n);
    logic [15:0] so;
    xfer(d, n, so);
  endtask

  // 12-bit frame: ignored as a command, reads status
  task automatic peek(output int ovf, output int eom, output int row);
    logic [15:0] so;
    xfer(16'h0000, 12, so);
    ovf = int'(so[0]);
    eom = int'(so[1]);
    row = int'(so[5:2]);
  endtask

  task automatic wait_pulse(output int t);
    do step(1); while (!row_clk);
    t = cyc;
  endtask

  task automatic t_reset;
    chk("R3 miso idle", miso, 1);
    chk("R12 pwr reset", pwr, 0);
    chk("R4 ready reset", ready, 0);
    chk("R5 run reset", run, 0);
    chk("R8 int reset", int_n, 1);
  endtask

  task automatic t_power;
    int o, e, r;
    send(cmd16(0, 0, 0, 1, 0, 1), 16);
    chk("R4 run ignored while settling", run, 0);
    chk("R1 power applied", pwr, 1);
    chk("R4 ready low while settling", ready, 0);
    step(2 * ST + 10);
    chk("R4 ready after settle", ready, 1);
    peek(o, e, r);
    chk("R3 peek ovf", o, 0);
    chk("R3 peek row", r, 0);
    send(16'hFFFF, 12);
    chk("R2 odd length ignored run", run, 0);
    chk("R2 odd length ignored pwr", pwr, 1);
  endtask

  task automatic t_record;
    int t1, t2, o, e, r;
    send(cmd16(2, 0, 0, 1, 0, 1), 16);
    chk("R1 run started", run, 1);
    chk("R1 record mode", play, 0);
    wait_pulse(t1);
    wait_pulse(t2);
    chk("R5 row period", t2 - t1, ROWC);
    peek(o, e, r);
    chk("R6 row repeats", r, 2);
    send(cmd16(9, 0, 1, 1, 0, 1), 16);
    wait_pulse(t1);
    wait_pulse(t1);
    wait_pulse(t1);
    send(cmd8(0, 0, 1, 0, 0), 8);
    chk("R2 short stop", run, 0);
    peek(o, e, r);
    chk("R7 advanced row", r, 5);
    chk("R7 no flags", o + e, 0);
  endtask

  task automatic t_play_eom;
    int o, e, r;
    send(cmd16(2, 0, 0, 1, 1, 1), 16);
    chk("R1 play mode", play, 1);
    send(cmd16(0, 0, 1, 1, 1, 1), 16);
    step(5 * ROWC);
    chk("R9 play stops", run, 0);
    chk("R9 int low", int_n, 0);
    peek(o, e, r);
    chk("R9 eom flag", e, 1);
    chk("R9 stop row", r, 5);
    chk("R10 int released", int_n, 1);
    peek(o, e, r);
    chk("R10 eom cleared", e, 0);
    send(cmd8(0, 0, 1, 1, 1), 8);
    step(ROWC + ROWC / 2);
    chk("R2 short run ended", run, 0);
    peek(o, e, r);
    chk("R2 short keeps row", r, 5);
    chk("R2 short eom", e, 1);
  endtask

  task automatic t_cue;
    int t1, t2;
    send(cmd16(2, 1, 0, 1, 1, 1), 16);
    wait_pulse(t1);
    wait_pulse(t2);
    chk("R11 cue period", t2 - t1, CUEC);
    send(cmd8(0, 0, 1, 1, 0), 8);
    send(cmd16(7, 1, 0, 1, 0, 1), 16);
    wait_pulse(t1);
    wait_pulse(t2);
    chk("R11 cue ignored on record", t2 - t1, ROWC);
    send(cmd8(0, 0, 1, 0, 0), 8);
    chk("R11 stopped", run, 0);
  endtask

  task automatic t_overflow;
    int o, e, r;
    send(cmd16(NR - 2, 0, 0, 1, 0, 1), 16);
    send(cmd16(0, 0, 1, 1, 0, 1), 16);
    step(3 * ROWC + 100);
    chk("R8 run stops", run, 0);
    chk("R8 int low", int_n, 0);
    peek(o, e, r);
    chk("R8 ovf flag", o, 1);
    chk("R8 last row", r, NR - 1);
    chk("R10 int high after read", int_n, 1);
    peek(o, e, r);
    chk("R10 ovf cleared", o, 0);
  endtask

  task automatic t_powerdown;
    send(cmd16(1, 0, 0, 1, 0, 1), 16);
    chk("R12 running before", run, 1);
    send(cmd16(1, 0, 0, 0, 0, 0), 16);
    chk("R12 run dropped", run, 0);
    chk("R12 pwr dropped", pwr, 0);
    chk("R12 ready dropped", ready, 0);
    send(cmd16(1, 0, 0, 1, 0, 1), 16);
    chk("R4 run refused after wake", run, 0);
  endtask

  initial begin
    step(5);
    rst_n = 1'b1;
    step(5);
    t_reset;
    t_power;
    t_record;
    t_play_eom;
    t_cue;
    t_overflow;
    t_powerdown;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule